// File: doc/BRIEF.md
# Serial Flash Identity and Geometry Probe

This block wakes up once after reset and interrogates a serial, page-buffered flash part over a four-wire SPI link in mode 0. It clocks out the identification opcode and captures three reply bytes. It checks the vendor code and the family bits. It then turns the packed capacity field into a page-size exponent and a page count. A recognised part is next polled through its status register until it reports ready. The status byte also tells whether the part is in the power-of-two page layout. A part in the other layout receives a fixed four-byte command that switches its page layout, and the probe ends with a distinct error, because the new layout only takes effect after the part is power-cycled.

The results are plain control and status pins, not a stream, so no valid/ready handshake applies. A single-bit `done` rises when the probe has finished and then holds. `err_code` says how it ended, and `valid` qualifies the geometry outputs. The page size in bytes is `1 << page_shift`. The erase unit is equal to the page size, and the number of erase units is `page_count`. The SPI bit rate is set by the `SCLK_HALF` parameter, which gives the number of system clocks per half SCLK period.

Top module: `flash_geom_probe`

## Requirements
- R1: The first chip-select window carries opcode 0x9F, sent MSB first in SPI mode 0, followed by three bytes clocked in: vendor, device byte A and device byte B. The window is 4 bytes long.
- R2: If the vendor byte is not 0x1F, or if bits 7..5 of device byte A are not 001, the probe ends with err_code 1 and opens no further window.
- R3: Capacity field A[4:0] maps to (page_shift, page_count) as follows: 0x02→(8,512), 0x03→(8,1024), 0x04→(8,2048), 0x05→(8,4096), 0x06→(9,4096), 0x07→(9,8192), 0x08→(10,8192).
- R4: Any other capacity code ends the probe with err_code 2 and no status window.
- R5: After an accepted ID, the probe repeats 2-byte windows of opcode 0xD7 plus one status byte until status bit 7 (ready) reads 1. Bit 0 of a busy reply is ignored.
- R6: A ready status with bit 0 = 1 ends the probe with err_code 0 and valid = 1.
- R7: A ready status with bit 0 = 0 causes one window with bytes 3D, 2A, 80, A6, in that order, and ends the probe with err_code 3 and valid = 0.
- R8: done rises once per reset and stays high. After it rises, chip select stays high and err_code does not change. page_shift and page_count read 0 whenever valid is 0.
- R9: During reset, cs_n = 1, sclk = 0, done = 0, valid = 0 and err_code = 0.
- R10: SCLK idles low and is high only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the probe starts when it is released |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | Probe finished (sticky) |
| valid | output | 1 | Geometry valid (err_code is 0) |
| err_code | output | 2 | 0 ok, 1 unknown vendor/family, 2 unsupported capacity, 3 page layout reprogrammed |
| page_shift | output | 4 | log2 of page size in bytes |
| page_count | output | 14 | Number of pages, which equals the number of erase units |

## Verification
Readiness and page layout are both read from the same status byte, so the two decisions fall in the same cycle. The bench provokes this with a busy reply of 0x01, whose layout bit is already set, followed by a ready reply. Any early acceptance then shows up as too few status windows. A ready reply of 0x80 must take the reprogram path rather than the success path. The bench judges these cases by counting windows and opcodes seen at the flash model's pins and by reading the final error code.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
  localparam int PCNT_W  = 14;
  localparam int SHIFT_W = 4;

  localparam logic [7:0] OP_IDREAD = 8'h9F;
  localparam logic [7:0] OP_STATUS = 8'hD7;
  localparam logic [7:0] VENDOR_ID = 8'h1F;
  localparam logic [2:0] FAMILY_ID = 3'b001;

  typedef enum logic [1:0] {
    E_OK     = 2'd0,
    E_NODEV  = 2'd1,
    E_UNSUP  = 2'd2,
    E_REPROG = 2'd3
  } probe_err_t;

  typedef enum logic [1:0] {PH_ID, PH_SR, PH_CFG} phase_t;

  typedef enum logic [2:0] {S_BOOT, S_XFER, S_WAIT, S_GAP, S_FIN} state_t;

  // binary page layout command, sent in order
  function automatic logic [7:0] layout_byte(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h3D;
      2'd1:    return 8'h2A;
      2'd2:    return 8'h80;
      default: return 8'hA6;
    endcase
  endfunction
endpackage

// File: rtl/fgp_spi_byte.sv
module fgp_spi_byte #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       fin,
  output logic [7:0] rx
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [CW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx;
          div  <= '0;
          bitn <= '0;
          sclk <= 1'b0;
        end
      end else if (div == CW'(SCLK_HALF - 1)) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fgp_id_decode.sv
module fgp_id_decode
  import fgp_pkg::*;
(
  input  logic [7:0]         vendor,
  input  logic [7:0]         dev_a,
  output logic               id_ok,
  output logic               cap_ok,
  output logic [SHIFT_W-1:0] shift,
  output logic [PCNT_W-1:0]  pages
);
  logic [4:0] cap;
  logic [3:0] pexp;

  assign cap   = dev_a[4:0];
  assign id_ok = (vendor == VENDOR_ID) && (dev_a[7:5] == FAMILY_ID);

  always_comb begin
    cap_ok = 1'b1;
    shift  = '0;
    pexp   = '0;
    case (cap)
      5'h02, 5'h03, 5'h04, 5'h05: begin
        shift = SHIFT_W'(8);
        pexp  = 4'(cap) + 4'd7;
      end
      5'h06: begin shift = SHIFT_W'(9);  pexp = 4'd12; end
      5'h07: begin shift = SHIFT_W'(9);  pexp = 4'd13; end
      5'h08: begin shift = SHIFT_W'(10); pexp = 4'd13; end
      default: cap_ok = 1'b0;
    endcase
    pages = cap_ok ? (PCNT_W'(1) << pexp) : '0;
  end
endmodule

// File: rtl/flash_geom_probe.sv
module flash_geom_probe
  import fgp_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  spi_sclk,
  output logic                  spi_cs_n,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic                  done,
  output logic                  valid,
  output logic [1:0]            err_code,
  output logic [SHIFT_W-1:0]    page_shift,
  output logic [PCNT_W-1:0]     page_count
);
  state_t     st;
  phase_t     ph;
  logic [1:0] idx;
  logic [1:0] last_idx;
  logic [7:0] vendor_q, dev_a_q, status_q;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic       eng_busy, eng_fin;
  logic       id_ok, cap_ok;
  logic [SHIFT_W-1:0] dec_shift;
  logic [PCNT_W-1:0]  dec_pages;

  fgp_spi_byte #(.SCLK_HALF(SCLK_HALF)) u_byte (
    .clk   (clk),
    .rst_n (rst_n),
    .start (st == S_XFER),
    .tx    (tx_byte),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .busy  (eng_busy),
    .fin   (eng_fin),
    .rx    (rx_byte)
  );

  fgp_id_decode u_dec (
    .vendor (vendor_q),
    .dev_a  (dev_a_q),
    .id_ok  (id_ok),
    .cap_ok (cap_ok),
    .shift  (dec_shift),
    .pages  (dec_pages)
  );

  assign spi_cs_n = !((st == S_XFER) || (st == S_WAIT));

  always_comb begin
    case (ph)
      PH_ID:   begin tx_byte = (idx == 2'd0) ? OP_IDREAD : 8'hFF; last_idx = 2'd3; end
      PH_SR:   begin tx_byte = (idx == 2'd0) ? OP_STATUS : 8'hFF; last_idx = 2'd1; end
      default: begin tx_byte = layout_byte(idx);                   last_idx = 2'd3; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_BOOT;
      ph         <= PH_ID;
      idx        <= '0;
      vendor_q   <= '0;
      dev_a_q    <= '0;
      status_q   <= '0;
      done       <= 1'b0;
      valid      <= 1'b0;
      err_code   <= E_OK;
      page_shift <= '0;
      page_count <= '0;
    end else begin
      case (st)
        S_BOOT: begin
          ph  <= PH_ID;
          idx <= '0;
          st  <= S_XFER;
        end
        S_XFER: st <= S_WAIT;
        S_WAIT: if (eng_fin && !eng_busy) begin
          if (ph == PH_ID && idx == 2'd1) vendor_q <= rx_byte;
          if (ph == PH_ID && idx == 2'd2) dev_a_q  <= rx_byte;
          if (ph == PH_SR && idx == 2'd1) status_q <= rx_byte;
          if (idx == last_idx) st <= S_GAP;
          else begin
            idx <= idx + 2'd1;
            st  <= S_XFER;
          end
        end
        S_GAP: begin
          idx <= '0;
          case (ph)
            PH_ID: begin
              if (!id_ok) begin
                st <= S_FIN; done <= 1'b1; err_code <= E_NODEV;
              end else if (!cap_ok) begin
                st <= S_FIN; done <= 1'b1; err_code <= E_UNSUP;
              end else begin
                ph <= PH_SR; st <= S_XFER;
              end
            end
            PH_SR: begin
              if (!status_q[7]) begin
                st <= S_XFER;
              end else if (status_q[0]) begin
                st         <= S_FIN;
                done       <= 1'b1;
                valid      <= 1'b1;
                err_code   <= E_OK;
                page_shift <= dec_shift;
                page_count <= dec_pages;
              end else begin
                ph <= PH_CFG; st <= S_XFER;
              end
            end
            default: begin
              st <= S_FIN; done <= 1'b1; err_code <= E_REPROG;
            end
          endcase
        end
        default: st <= S_FIN;
      endcase
    end
  end
endmodule

// File: rtl/fgp_chk.sv
module fgp_chk
  import fgp_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               spi_sclk,
  input logic               spi_cs_n,
  input logic               done,
  input logic               valid,
  input logic [1:0]         err_code,
  input logic [SHIFT_W-1:0] page_shift,
  input logic [PCNT_W-1:0]  page_count
);
  assert_sclk_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

  assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(err_code));

  assert_geom_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (page_shift == '0 && page_count == '0));

  assert_valid_means_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (done && err_code == 2'd0));

  assert_ok_means_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd0) |-> valid);

  assert_geom_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (page_shift >= SHIFT_W'(8) && page_shift <= SHIFT_W'(10)
               && $countones(page_count) == 1));
endmodule

bind flash_geom_probe fgp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_sclk   (spi_sclk),
  .spi_cs_n   (spi_cs_n),
  .done       (done),
  .valid      (valid),
  .err_code   (err_code),
  .page_shift (page_shift),
  .page_count (page_count)
);

// File: tb/sim_flash_geom_probe.sv
`timescale 1ns/1ps
module sim_flash_geom_probe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b1;
  logic        done, valid;
  logic [1:0]  err_code;
  logic [3:0]  page_shift;
  logic [13:0] page_count;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  flash_geom_probe u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done), .valid(valid),
    .err_code(err_code), .page_shift(page_shift), .page_count(page_count)
  );

  // ---------------- flash model ----------------
  logic [7:0] m_id [3];
  int         m_busy_polls;
  logic [7:0] m_status;
  int         bitc;
  logic [7:0] inb;
  logic [7:0] op;
  logic [7:0] wb [8];
  int         nb;
  int         win_cnt;
  logic [7:0] win_op [32];
  int         win_len [32];
  int         sr_wins;
  logic [7:0] cfg_seen [4];
  int         stray_sclk;

  function automatic logic [7:0] reply_byte(input int k);
    if (op == 8'h9F && k >= 1 && k <= 3) return m_id[k-1];
    if (op == 8'hD7 && k == 1) return (sr_wins < m_busy_polls) ? 8'h01 : m_status;
    return 8'hFF;
  endfunction

  always @(negedge spi_cs_n) begin
    bitc = 0; nb = 0; op = 8'h00;
    spi_miso = 1'b1;
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n) stray_sclk++;
    else begin
      inb = {inb[6:0], spi_mosi};
      bitc++;
      if (bitc % 8 == 0) begin
        if (nb < 8) wb[nb] = inb;
        nb++;
        if (bitc == 8) op = inb;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      automatic logic [7:0] b = reply_byte(bitc / 8);
      spi_miso = b[7 - (bitc % 8)];
    end
  end

  always @(posedge spi_cs_n) begin
    if (nb > 0 && win_cnt < 32) begin
      win_op[win_cnt]  = wb[0];
      win_len[win_cnt] = nb;
      if (wb[0] == 8'hD7) sr_wins++;
      if (wb[0] == 8'h3D) for (int i = 0; i < 4; i++) cfg_seen[i] = wb[i];
      win_cnt++;
      nb = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_probe(input logic [7:0] v, input logic [7:0] a, input int busy,
                           input logic [7:0] sr, output bit ok);
    rst_n = 1'b0;
    m_id[0] = v; m_id[1] = a; m_id[2] = 8'h00;
    m_busy_polls = busy; m_status = sr;
    repeat (3) @(negedge clk);
    win_cnt = 0; sr_wins = 0; stray_sclk = 0; nb = 0;
    for (int i = 0; i < 4; i++) cfg_seen[i] = 8'h00;
    rst_n = 1'b1;
    ok = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: probe did not finish, actual done=0 expected 1");
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 cs_n", 32'(spi_cs_n), 1);
    chk("R9 sclk", 32'(spi_sclk), 0);
    chk("R9 done", 32'(done), 0);
    chk("R9 valid", 32'(valid), 0);
    chk("R9 err", 32'(err_code), 0);
  endtask

  task automatic t_geom(input logic [4:0] cap, input int shift, input int pages);
    bit ok;
    run_probe(8'h1F, {3'b001, cap}, 0, 8'h81, ok);
    chk("R6 err", 32'(err_code), 0);
    chk("R6 valid", 32'(valid), 1);
    chk("R3 shift", 32'(page_shift), 32'(shift));
    chk("R3 pages", 32'(page_count), 32'(pages));
    chk("R1 id opcode", 32'(win_op[0]), 32'h9F);
    chk("R1 id length", 32'(win_len[0]), 4);
    chk("R5 status opcode", 32'(win_op[1]), 32'hD7);
    chk("R5 status length", 32'(win_len[1]), 2);
    chk("R10 sclk outside window", 32'(stray_sclk), 0);
  endtask

  task automatic t_bad_id(input logic [7:0] v, input logic [7:0] a);
    bit ok;
    run_probe(v, a, 0, 8'h81, ok);
    chk("R2 err", 32'(err_code), 1);
    chk("R2 windows", 32'(win_cnt), 1);
    chk("R8 gated shift", 32'(page_shift), 0);
    chk("R8 gated pages", 32'(page_count), 0);
  endtask

  task automatic t_unsup(input logic [4:0] cap);
    bit ok;
    run_probe(8'h1F, {3'b001, cap}, 0, 8'h81, ok);
    chk("R4 err", 32'(err_code), 2);
    chk("R4 no status window", 32'(win_cnt), 1);
    chk("R4 valid", 32'(valid), 0);
  endtask

  task automatic t_busy();
    bit ok;
    run_probe(8'h1F, 8'h27, 3, 8'h81, ok);
    chk("R5 status polls", 32'(sr_wins), 4);
    chk("R5 err after busy", 32'(err_code), 0);
    chk("R5 shift after busy", 32'(page_shift), 9);
  endtask

  task automatic t_reprog();
    bit ok;
    run_probe(8'h1F, 8'h26, 1, 8'h80, ok);
    chk("R7 err", 32'(err_code), 3);
    chk("R7 valid", 32'(valid), 0);
    chk("R7 windows", 32'(win_cnt), 4);
    chk("R7 length", 32'(win_len[3]), 4);
    chk("R7 byte0", 32'(cfg_seen[0]), 32'h3D);
    chk("R7 byte1", 32'(cfg_seen[1]), 32'h2A);
    chk("R7 byte2", 32'(cfg_seen[2]), 32'h80);
    chk("R7 byte3", 32'(cfg_seen[3]), 32'hA6);
    chk("R8 gated pages", 32'(page_count), 0);
  endtask

  task automatic t_quiet();
    bit ok;
    int w;
    run_probe(8'h1F, 8'h24, 0, 8'h81, ok);
    w = win_cnt;
    repeat (300) @(negedge clk);
    chk("R8 done held", 32'(done), 1);
    chk("R8 no new window", 32'(win_cnt), 32'(w));
    chk("R8 code held", 32'(err_code), 0);
    chk("R8 pages held", 32'(page_count), 2048);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_geom(5'h02, 8, 512);
    t_geom(5'h03, 8, 1024);
    t_geom(5'h04, 8, 2048);
    t_geom(5'h05, 8, 4096);
    t_geom(5'h06, 9, 4096);
    t_geom(5'h07, 9, 8192);
    t_geom(5'h08, 10, 8192);
    t_bad_id(8'h1E, 8'h26);
    t_bad_id(8'h1F, 8'h46);
    t_unsup(5'h09);
    t_unsup(5'h01);
    t_busy();
    t_reprog();
    t_quiet();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule